// File: doc/BRIEF.md
# Timer Bank Register Front End

This block is the bus-facing half of an eight-channel down-counting timer bank. It takes single-word register accesses, steers them to one of eight timer channels (each with a status, reload and two match words), and keeps two control words of its own: a shared word holding a four-bit configuration nibble per channel, and a general-purpose word passed straight out. The counting logic sits outside; it receives write strobes, the word select and the write data, and hands back the currently selected word of each channel for readback.

A write to the shared control word is not applied all at once. Channels being switched off lose their enable on the write edge, the clock-source, overflow-interrupt and pulse settings move one cycle later, and channels being switched on see their enable rise together with a single-cycle start strobe one cycle after that. A counter therefore never runs with a stale configuration, and never starts before its new configuration is in place.

Top module: `tmr_bank_regs`

## Requirements
- R1: After reset both control words read as zero and every enable, start, clock-select, overflow-interrupt, pulse and general-control output is low.
- R2: Aligned addresses 0x000, 0x010 and 0x020 (plus word offsets) select channels 0, 1 and 2; a write raises only that channel's bit of `tmr_we_o` for the write cycle, with `tmr_reg_o` = addr[3:2] (0 status, 1 reload, 2 first match, 3 second match), and a read returns that channel's slice of `tmr_rdata_i`.
- R3: Aligned addresses 0x040 through 0x08C select channels 3 to 7, the channel being addr[7:4] minus one, with the same word select and read path as R2.
- R4: Address 0x030 is the shared control word and 0x034 the general control word; both read back the last written value and the general word drives `gen_ctrl_o`.
- R5: Addresses 0x038 and 0x03C, addresses from 0x090 up, any address with a nonzero bit above bit 7, and any address with addr[1:0] not zero read as 0, raise no write strobe and change no state.
- R6: Channel n owns shared-control bits [4n+3:4n]: bit 0 enable, bit 1 external clock select (`ext_clk_o`), bit 2 overflow interrupt enable (`ovf_irq_en_o`), bit 3 pulse mode (`pulse_en_o`).
- R7: The pulse bit reaches `pulse_en_o` only for channels 4 to 7; for channels 0 to 3 it is stored and read back but the output stays low.
- R8: For a control write accepted on edge T, enables that clear drop on edge T, clock-select, interrupt and pulse outputs take the new value on edge T+1, and enables that set rise on edge T+2.
- R9: `start_o[n]` is high for exactly the one cycle after edge T+2 for each channel whose enable went from 0 to 1, and stays low for channels already enabled.
- R10: If a later control write clears a channel's enable before its pending enable has landed, that channel neither rises nor strobes `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data, little-endian word |
| rdata_o | output | 32 | Read data, valid in the request cycle of a read |
| tmr_we_o | output | 8 | Per-channel register write strobe |
| tmr_reg_o | output | 2 | Word select within a channel |
| tmr_wdata_o | output | 32 | Data for channel register writes |
| tmr_rdata_i | input | 256 | Selected word of each channel, channel n at bits [32n+31:32n] |
| en_o | output | 8 | Per-channel count enable |
| start_o | output | 8 | Per-channel one-cycle start strobe |
| ext_clk_o | output | 8 | Per-channel external clock select |
| ovf_irq_en_o | output | 8 | Per-channel overflow interrupt enable |
| pulse_en_o | output | 8 | Per-channel pulse mode |
| gen_ctrl_o | output | 32 | General control word |

## Verification
The hardest situation to reach is a control write that lands while an earlier one is still in flight, so that a pending enable must be cancelled by the newer value. The bench issues two control writes on consecutive cycles, the first switching a channel on and the second switching it off again, and then watches that channel's enable and start outputs for several cycles. The address decode corners (the control gap, the shifted upper channels, aliasing above bit 7 and misaligned words) are walked from a vector table with a count of write strobes kept beside it.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int CFG_W = 4;
  localparam int B_EN  = 0;
  localparam int B_EXT = 1;
  localparam int B_OVF = 2;
  localparam int B_PLS = 3;

  typedef enum logic [1:0] {
    W_STATUS = 2'd0,
    W_RELOAD = 2'd1,
    W_MATCH0 = 2'd2,
    W_MATCH1 = 2'd3
  } tmr_word_e;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
  parameter int AW        = 12,
  parameter int N_TMR     = 8,
  parameter int CTRL_SLOT = 3,
  parameter int IDX_W     = $clog2(N_TMR)
) (
  input  logic [AW-1:0]    addr_i,
  output logic             tmr_hit_o,
  output logic             ctrl_hit_o,
  output logic             gen_hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       word_o
);
  localparam int SW = AW - 4;
  localparam logic [SW-1:0] CS   = SW'(CTRL_SLOT);
  localparam logic [SW-1:0] LAST = SW'(N_TMR);

  logic [SW-1:0] slot, slot_m1;
  logic          aligned;

  assign slot    = addr_i[AW-1:4];
  assign slot_m1 = slot - SW'(1);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign word_o  = addr_i[3:2];

  always_comb begin
    tmr_hit_o  = 1'b0;
    ctrl_hit_o = 1'b0;
    gen_hit_o  = 1'b0;
    idx_o      = '0;
    if (aligned) begin
      if (slot == CS) begin
        ctrl_hit_o = (word_o == 2'd0);
        gen_hit_o  = (word_o == 2'd1);
      end else if (slot < CS) begin
        tmr_hit_o = 1'b1;
        idx_o     = slot[IDX_W-1:0];
      end else if (slot <= LAST) begin
        // channels above the control slot are shifted down by one
        tmr_hit_o = 1'b1;
        idx_o     = slot_m1[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
  import tmr_bank_pkg::*;
#(
  parameter int N_TMR       = 8,
  parameter int PULSE_FIRST = 4,
  localparam int CW         = CFG_W * N_TMR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CW-1:0]    wdata_i,
  output logic [CW-1:0]    ctrl_o,
  output logic [N_TMR-1:0] en_o,
  output logic [N_TMR-1:0] start_o,
  output logic [N_TMR-1:0] ext_o,
  output logic [N_TMR-1:0] ovf_o,
  output logic [N_TMR-1:0] pls_o
);
  logic [CW-1:0]    ctrl_q;
  logic [N_TMR-1:0] cur_en, new_en, new_ext, new_ovf, new_pls, pls_cap;
  logic [N_TMR-1:0] fall_w, rise_w, en_set;
  // stage 1: captured write
  logic             cfg_vld_q;
  logic [N_TMR-1:0] ext_p_q, ovf_p_q, pls_p_q, rise_p_q;
  // stage 2: configuration applied
  logic [N_TMR-1:0] ext_q, ovf_q, pls_q, arm_q;
  // stage 3: enable applied
  logic [N_TMR-1:0] en_q, start_q;

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_fld
    assign cur_en[gi]  = ctrl_q[gi*CFG_W + B_EN];
    assign new_en[gi]  = wdata_i[gi*CFG_W + B_EN];
    assign new_ext[gi] = wdata_i[gi*CFG_W + B_EXT];
    assign new_ovf[gi] = wdata_i[gi*CFG_W + B_OVF];
    assign new_pls[gi] = wdata_i[gi*CFG_W + B_PLS];
    if (gi >= PULSE_FIRST) begin : g_pls
      assign pls_cap[gi] = 1'b1;
    end else begin : g_nopls
      assign pls_cap[gi] = 1'b0;
    end
  end

  assign fall_w = wr_i ? (cur_en & ~new_en) : '0;
  assign rise_w = wr_i ? (~cur_en & new_en) : '0;
  // a pending enable lands only if the current control word still asks for it
  assign en_set = arm_q & cur_en & ~fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      cfg_vld_q <= 1'b0;
      ext_p_q   <= '0;
      ovf_p_q   <= '0;
      pls_p_q   <= '0;
      rise_p_q  <= '0;
      ext_q     <= '0;
      ovf_q     <= '0;
      pls_q     <= '0;
      arm_q     <= '0;
      en_q      <= '0;
      start_q   <= '0;
    end else begin
      if (wr_i) begin
        ctrl_q  <= wdata_i;
        ext_p_q <= new_ext;
        ovf_p_q <= new_ovf;
        pls_p_q <= new_pls & pls_cap;
      end
      cfg_vld_q <= wr_i;
      rise_p_q  <= rise_w;
      if (cfg_vld_q) begin
        ext_q <= ext_p_q;
        ovf_q <= ovf_p_q;
        pls_q <= pls_p_q;
      end
      arm_q   <= rise_p_q;
      en_q    <= (en_q & ~fall_w) | en_set;
      start_q <= en_set;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign en_o    = en_q;
  assign start_o = start_q;
  assign ext_o   = ext_q;
  assign ovf_o   = ovf_q;
  assign pls_o   = pls_q;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int N_TMR = 8,
  parameter int DW    = 32,
  parameter int CW    = 32,
  parameter int IDX_W = $clog2(N_TMR)
) (
  input  logic                rd_i,
  input  logic                tmr_hit_i,
  input  logic                ctrl_hit_i,
  input  logic                gen_hit_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [CW-1:0]       ctrl_i,
  input  logic [DW-1:0]       gen_i,
  input  logic [N_TMR*DW-1:0] tmr_rdata_i,
  output logic [DW-1:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (ctrl_hit_i)     rdata_o = DW'(ctrl_i);
      else if (gen_hit_i) rdata_o = gen_i;
      else if (tmr_hit_i) rdata_o = tmr_rdata_i[idx_i*DW +: DW];
    end
  end
endmodule

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs
  import tmr_bank_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int N_TMR       = 8,
  parameter int CTRL_SLOT   = 3,
  parameter int PULSE_FIRST = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [N_TMR-1:0]    tmr_we_o,
  output logic [1:0]          tmr_reg_o,
  output logic [DW-1:0]       tmr_wdata_o,
  input  logic [N_TMR*DW-1:0] tmr_rdata_i,
  output logic [N_TMR-1:0]    en_o,
  output logic [N_TMR-1:0]    start_o,
  output logic [N_TMR-1:0]    ext_clk_o,
  output logic [N_TMR-1:0]    ovf_irq_en_o,
  output logic [N_TMR-1:0]    pulse_en_o,
  output logic [DW-1:0]       gen_ctrl_o
);
  localparam int IDX_W = $clog2(N_TMR);
  localparam int CW    = CFG_W * N_TMR;

  logic             tmr_hit, ctrl_hit, gen_hit, wr, rd;
  logic [IDX_W-1:0] idx;
  logic [1:0]       word;
  logic [CW-1:0]    ctrl;
  logic [DW-1:0]    gen_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  tmr_addr_dec #(
    .AW(AW), .N_TMR(N_TMR), .CTRL_SLOT(CTRL_SLOT), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i    (addr_i),
    .tmr_hit_o (tmr_hit),
    .ctrl_hit_o(ctrl_hit),
    .gen_hit_o (gen_hit),
    .idx_o     (idx),
    .word_o    (word)
  );

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_we
    assign tmr_we_o[gi] = wr & tmr_hit & (idx == IDX_W'(gi));
  end
  assign tmr_reg_o   = word;
  assign tmr_wdata_o = wdata_i;

  tmr_ctrl_seq #(
    .N_TMR(N_TMR), .PULSE_FIRST(PULSE_FIRST)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr & ctrl_hit),
    .wdata_i(wdata_i[CW-1:0]),
    .ctrl_o (ctrl),
    .en_o   (en_o),
    .start_o(start_o),
    .ext_o  (ext_clk_o),
    .ovf_o  (ovf_irq_en_o),
    .pls_o  (pulse_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gen_q <= '0;
    else if (wr && gen_hit) gen_q <= wdata_i;
  end
  assign gen_ctrl_o = gen_q;

  tmr_rd_mux #(
    .N_TMR(N_TMR), .DW(DW), .CW(CW), .IDX_W(IDX_W)
  ) u_rd (
    .rd_i       (rd),
    .tmr_hit_i  (tmr_hit),
    .ctrl_hit_i (ctrl_hit),
    .gen_hit_i  (gen_hit),
    .idx_i      (idx),
    .ctrl_i     (ctrl),
    .gen_i      (gen_q),
    .tmr_rdata_i(tmr_rdata_i),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N_TMR = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [N_TMR-1:0] tmr_we_o,
  input logic [N_TMR-1:0] en_o,
  input logic [N_TMR-1:0] start_o,
  input logic [N_TMR-1:0] ext_clk_o,
  input logic [N_TMR-1:0] ovf_irq_en_o,
  input logic [N_TMR-1:0] pulse_en_o
);
  p_we_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tmr_we_o));

  p_we_needs_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_we_o != '0) |-> (req_i && we_i));

  p_fall_after_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(en_o) & ~en_o) != '0) |-> $past(req_i && we_i));

  p_cfg_not_with_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ext_clk_o != $past(ext_clk_o)) || (ovf_irq_en_o != $past(ovf_irq_en_o)) ||
     (pulse_en_o != $past(pulse_en_o))) |-> ((en_o & ~$past(en_o)) == '0));

  p_start_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o == (en_o & ~$past(en_o)));

  p_start_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |=> ((start_o & $past(start_o)) == '0));
endmodule

bind tmr_bank_regs tmr_bank_chk #(.N_TMR(N_TMR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .tmr_we_o    (tmr_we_o),
  .en_o        (en_o),
  .start_o     (start_o),
  .ext_clk_o   (ext_clk_o),
  .ovf_irq_en_o(ovf_irq_en_o),
  .pulse_en_o  (pulse_en_o)
);

// File: tb/tmr_bank_regs_bench.sv
module tmr_bank_regs_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [11:0]  addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [7:0]   tmr_we_o;
  logic [1:0]   tmr_reg_o;
  logic [31:0]  tmr_wdata_o;
  logic [255:0] tmr_rdata_i;
  logic [7:0]   en_o, start_o, ext_clk_o, ovf_irq_en_o, pulse_en_o;
  logic [31:0]  gen_ctrl_o;

  int n_chk = 0;
  int n_fail = 0;
  int we_cnt = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tmr_bank_regs u_tmr_bank_regs (.*);

  // channel register model
  logic [31:0] tm [8][4];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 4; j++) tm[i][j] <= '0;
    end else begin
      for (int i = 0; i < 8; i++)
        if (tmr_we_o[i]) tm[i][tmr_reg_o] <= tmr_wdata_o;
    end
  end
  always_comb
    for (int i = 0; i < 8; i++) tmr_rdata_i[i*32 +: 32] = tm[i][tmr_reg_o];

  always @(posedge clk_i) if (tmr_we_o != '0) we_cnt++;

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  idx;  // 4'hF = no channel
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{12'h000, 32'h1000_0001, 4'd0,  4'd2},  // R2 status ch0
    '{12'h014, 32'h2000_0002, 4'd1,  4'd2},  // R2 reload ch1
    '{12'h028, 32'h3000_0003, 4'd2,  4'd2},  // R2 match0 ch2
    '{12'h04C, 32'h4000_0004, 4'd3,  4'd3},  // R3 match1 ch3
    '{12'h050, 32'h5000_0005, 4'd4,  4'd3},  // R3 status ch4
    '{12'h084, 32'h8000_0008, 4'd7,  4'd3},  // R3 reload ch7
    '{12'h038, 32'hDEAD_0001, 4'hF,  4'd5},  // R5 reserved
    '{12'h03C, 32'hDEAD_0002, 4'hF,  4'd5},  // R5 reserved
    '{12'h090, 32'hDEAD_0003, 4'hF,  4'd5},  // R5 past last channel
    '{12'h0A4, 32'hDEAD_0004, 4'hF,  4'd5},  // R5 unmapped
    '{12'h104, 32'hDEAD_0005, 4'hF,  4'd5},  // R5 high bit set
    '{12'h046, 32'hDEAD_0006, 4'hF,  4'd5}   // R5 misaligned
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    @(negedge clk_i);
    chk("R1 en",    32'(en_o), 0);
    chk("R1 start", 32'(start_o), 0);
    chk("R1 cfg",   32'({ext_clk_o, ovf_irq_en_o, pulse_en_o}), 0);
    chk("R1 gen",   gen_ctrl_o, 0);
    bus_rd(12'h030, rd); chk("R1 ctrl read", rd, 0);
    bus_rd(12'h034, rd); chk("R1 gen read", rd, 0);

    // R2 R3 R5 decode table
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      bit ok = (v.idx != 4'hF);
      c0 = we_cnt;
      bus_wr(v.addr, v.data);
      chk($sformatf("R%0d strobe count @%h", v.rq, v.addr), we_cnt, c0 + (ok ? 1 : 0));
      bus_rd(v.addr, rd);
      chk($sformatf("R%0d readback @%h", v.rq, v.addr), rd, ok ? v.data : 32'h0);
      if (ok) chk($sformatf("R%0d channel word @%h", v.rq, v.addr),
                  tm[v.idx[2:0]][v.addr[3:2]], v.data);
    end
    bus_rd(12'h030, rd); chk("R5 ctrl untouched", rd, 0);
    bus_rd(12'h034, rd); chk("R5 gen untouched", rd, 0);

    // R8 R9 enable all from idle
    bus_wr(12'h030, 32'h1111_1111);
    chk("R8 no early enable T", 32'(en_o), 0);
    @(negedge clk_i);
    chk("R8 no early enable T+1", 32'(en_o), 0);
    chk("R9 no early start", 32'(start_o), 0);
    @(negedge clk_i);
    chk("R8 enable T+2", 32'(en_o), 32'hFF);
    chk("R9 start T+2", 32'(start_o), 32'hFF);
    @(negedge clk_i);
    chk("R9 start one cycle", 32'(start_o), 0);

    // R6 R7 R8 mixed change: ch0 off+ext, ch1 ovf, ch2 pulse ignored, ch5 pulse
    bus_wr(12'h030, 32'h0090_0952);
    chk("R8 disable first", 32'(en_o), 32'h26);
    chk("R8 cfg not yet", 32'(ext_clk_o), 0);
    @(negedge clk_i);
    chk("R6 ext", 32'(ext_clk_o), 32'h01);
    chk("R6 ovf", 32'(ovf_irq_en_o), 32'h02);
    chk("R7 pulse only upper", 32'(pulse_en_o), 32'h20);
    @(negedge clk_i);
    chk("R9 no start when held", 32'(start_o), 0);
    chk("R8 en held", 32'(en_o), 32'h26);

    // R9 single channel start
    bus_wr(12'h030, 32'h0090_0953);
    @(negedge clk_i);
    chk("R8 en waits for cfg", 32'(en_o), 32'h26);
    @(negedge clk_i);
    chk("R9 start ch0", 32'(start_o), 32'h01);
    chk("R8 en ch0", 32'(en_o), 32'h27);
    bus_rd(12'h030, rd); chk("R4 ctrl readback raw", rd, 32'h0090_0953);

    // R4 general word
    bus_wr(12'h034, 32'hA5A5_0001);
    chk("R4 gen out", gen_ctrl_o, 32'hA5A5_0001);
    bus_rd(12'h034, rd); chk("R4 gen read", rd, 32'hA5A5_0001);

    // R10 enable ch3 then clear it on the next cycle
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'h030; wdata_i = 32'h0090_1953;
    @(negedge clk_i);
    wdata_i = 32'h0090_0953;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      chk($sformatf("R10 no start c%0d", c), 32'(start_o), 0);
      chk($sformatf("R10 en unchanged c%0d", c), 32'(en_o), 32'h27);
      @(negedge clk_i);
    end

    summary();
  end
endmodule